// File: doc/BRIEF.md
# PCI Power Management Capability Registers

This block provides the power management capability structure that sits in the configuration space of a PCI function. Configuration reads and writes reach it through a dword-addressed port with byte enables. It returns a fixed capability header and capabilities word. It also holds the control/status dword, which contains the requested power state, a PME enable bit and a PME status bit.

The PME status bit records every wake event whether or not wake signalling is enabled. Software clears it by writing a one to it. The status bit and the enable bit keep their values through PCI reset: only the auxiliary power-on reset initialises them. The active-low PME# output comes straight from a flop. It is asserted while both the status bit and the enable bit are set, so it stays low until software clears the status.

Top module: `pcipm_cap`

## Requirements
- R1: A read of dword address 10h (byte offset 40h) returns 0x0022_0001. This value has a capability ID of 01h in bits 7:0, a next pointer of 00h in bits 15:8, version 010b in bits 18:16, bit 21 (device-specific initialisation) set, and every other bit clear.
- R2: A read of dword address 11h (byte offset 44h) returns the control/status dword. Status is in bit 15, enable in bit 8 and power state in bits 1:0. All other bits, including bits 31:16, read 0. Every other dword address reads 0.
- R3: A PME event input sampled high sets the PME status bit at that clock edge, whatever the value of the enable bit.
- R4: A write to 11h with byte enable 1 set and data bit 15 = 1 clears PME status. With data bit 15 = 0 the status bit is left unchanged.
- R5: When a PME event and a status-clearing write occur in the same cycle, PME status ends up set.
- R6: PME# (pme_n) is low exactly when status and enable are both 1. It is registered and changes at the same edge as the status and enable bits.
- R7: While pci_rst is high, the power state becomes 00b, configuration writes are ignored, and PME status and enable keep their values. Events still set the status bit during PCI reset.
- R8: While aux_por is high, status, enable and power state are cleared and pme_n is driven high.
- R9: The enable bit (bit 8) takes data bit 8 on a write to 11h with byte enable 1 set. A write without byte enable 1 leaves both bit 15 and bit 8 unchanged.
- R10: Power state bits 1:0 are written only when byte enable 0 is set. Only 00b (D0) and 11b (D3hot) are accepted. A write of 01b or 10b leaves the field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pci_rst | input | 1 | PCI reset, synchronous, active high; leaves the sticky bits alone |
| aux_por | input | 1 | Auxiliary power-on reset, synchronous, active high; clears everything |
| cfg_addr | input | 6 | Configuration dword address |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pme_event | input | 1 | Wake event, one cycle per event |
| pme_n | output | 1 | Active-low PME# from a flop |

## Verification
Two functions can fall in the same cycle: the event that sets PME status, and the software write that clears it. Another overlap is a PCI reset that arrives with a pending event or a write. The sweep derives event, write, byte enables, data bits and reset from the bits of a loop counter, so every one of these pairings occurs many times. After each edge, a bench model computes status, enable, power state and pme_n from the requirements and compares them at the ports. A directed race cycle confirms that the event wins over the clear.

// File: rtl/pcipm_pkg.sv
package pcipm_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [7:0] CAP_ID_PM   = 8'h01;
    localparam logic [7:0] CAP_NEXT    = 8'h00;
    localparam logic [2:0] PM_VERSION  = 3'b010;

    localparam int BIT_STATUS = 15;
    localparam int BIT_ENABLE = 8;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D1    = 2'b01,
        PS_D2    = 2'b10,
        PS_D3HOT = 2'b11
    } pstate_e;

    typedef struct packed {
        logic    status;
        logic    enable;
        pstate_e pstate;
    } csr_view_t;

    function automatic logic pstate_ok(input logic [1:0] code);
        return (code == PS_D0) || (code == PS_D3HOT);
    endfunction

    function automatic logic [DATA_W-1:0] header_word();
        logic [DATA_W-1:0] w;
        w        = '0;
        w[7:0]   = CAP_ID_PM;
        w[15:8]  = CAP_NEXT;
        w[18:16] = PM_VERSION;
        w[19]    = 1'b0;
        w[20]    = 1'b0;
        w[21]    = 1'b1;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] csr_word(input csr_view_t v);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[BIT_STATUS] = v.status;
        w[BIT_ENABLE] = v.enable;
        w[1:0]        = v.pstate;
        return w;
    endfunction

endpackage

// File: rtl/pcipm_wake.sv
module pcipm_wake (
    input  logic clk,
    input  logic aux_por,
    input  logic csr_we,
    input  logic be_hi,
    input  logic wd_status,
    input  logic wd_enable,
    input  logic pme_event,
    output logic status,
    output logic enable,
    output logic pme_n
);

    logic clr_req;
    logic st_nx;
    logic en_nx;

    always_comb begin
        clr_req = csr_we && be_hi && wd_status;
        st_nx   = pme_event || (status && !clr_req);
        en_nx   = (csr_we && be_hi) ? wd_enable : enable;
    end

    always_ff @(posedge clk) begin
        if (aux_por) begin
            status <= 1'b0;
            enable <= 1'b0;
            pme_n  <= 1'b1;
        end else begin
            status <= st_nx;
            enable <= en_nx;
            pme_n  <= !(st_nx && en_nx);
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (aux_por)
        pme_event |=> status);                                         // R3
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (aux_por)
        (pme_event && csr_we && be_hi && wd_status) |=> status);       // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (aux_por)
        (csr_we && be_hi && wd_status && !pme_event) |=> !status);     // R4
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (aux_por)
        !(csr_we && be_hi) |=> (enable == $past(enable)));              // R9
    AST_PIN_TRACKS: assert property (@(posedge clk) disable iff (aux_por)
        pme_n == !(status && enable));                                 // R6

endmodule

// File: rtl/pcipm_pstate.sv
module pcipm_pstate
    import pcipm_pkg::*;
(
    input  logic       clk,
    input  logic       aux_por,
    input  logic       pci_rst,
    input  logic       csr_we,
    input  logic       be_lo,
    input  logic [1:0] wd_ps,
    output pstate_e    pstate
);

    always_ff @(posedge clk) begin
        if (aux_por || pci_rst) begin
            pstate <= PS_D0;
        end else if (csr_we && be_lo && pstate_ok(wd_ps)) begin
            pstate <= pstate_e'(wd_ps);
        end
    end

    AST_PS_LEGAL: assert property (@(posedge clk) disable iff (aux_por)
        (pstate == PS_D0) || (pstate == PS_D3HOT));                    // R10
    AST_PS_REJECT: assert property (@(posedge clk) disable iff (aux_por)
        (csr_we && !pci_rst && !pstate_ok(wd_ps)) |=> (pstate == $past(pstate))); // R10
    AST_PS_PCIRST: assert property (@(posedge clk) disable iff (aux_por)
        pci_rst |=> (pstate == PS_D0));                                // R7

endmodule

// File: rtl/pcipm_cap.sv
module pcipm_cap
    import pcipm_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter logic [5:0]  HDR_DW  = 6'h10
) (
    input  logic              clk,
    input  logic              pci_rst,
    input  logic              aux_por,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              pme_event,
    output logic              pme_n
);

    localparam logic [ADDR_W-1:0] HDR_A = ADDR_W'(HDR_DW);
    localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(HDR_DW + 6'd1);

    logic      csr_we;
    csr_view_t view;
    logic      unused_bits;

    assign csr_we      = cfg_wr && !pci_rst && (cfg_addr == CSR_A);
    assign unused_bits = ^{cfg_wdata[31:16], cfg_wdata[14:9], cfg_wdata[7:2], cfg_be[3:2]};

    pcipm_wake u_wake (
        .clk       (clk),
        .aux_por   (aux_por),
        .csr_we    (csr_we),
        .be_hi     (cfg_be[1]),
        .wd_status (cfg_wdata[BIT_STATUS]),
        .wd_enable (cfg_wdata[BIT_ENABLE]),
        .pme_event (pme_event),
        .status    (view.status),
        .enable    (view.enable),
        .pme_n     (pme_n)
    );

    pcipm_pstate u_pstate (
        .clk     (clk),
        .aux_por (aux_por),
        .pci_rst (pci_rst),
        .csr_we  (csr_we),
        .be_lo   (cfg_be[0]),
        .wd_ps   (cfg_wdata[1:0]),
        .pstate  (view.pstate)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == HDR_A) begin
            cfg_rdata = header_word();
        end else if (cfg_addr == CSR_A) begin
            cfg_rdata = csr_word(view);
        end
    end

    AST_STICKY_PCIRST: assert property (@(posedge clk) disable iff (aux_por)
        (pci_rst && !pme_event) |=> (view.status == $past(view.status)
                                     && view.enable == $past(view.enable))); // R7
    AST_AUX_CLEAR: assert property (@(posedge clk)
        aux_por |=> (pme_n && !view.status && !view.enable && view.pstate == PS_D0)); // R8

endmodule

// File: tb/pcipm_cap_test.sv
`timescale 1ns/1ps
module pcipm_cap_test;

    logic        clk = 1'b0;
    logic        pci_rst = 1'b1;
    logic        aux_por = 1'b1;
    logic [5:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pme_event = 1'b0;
    logic        pme_n;

    int n_chk = 0;
    int n_fail = 0;
    logic m_st = 1'b0, m_en = 1'b0;
    logic [1:0] m_ps = 2'b00;

    always #5 clk = ~clk;

    pcipm_cap uut (
        .clk(clk), .pci_rst(pci_rst), .aux_por(aux_por), .cfg_addr(cfg_addr),
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pme_event(pme_event), .pme_n(pme_n)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        if (a == 6'h10) return 32'h0022_0001;
        if (a == 6'h11) return {16'h0, m_st, 6'h0, m_en, 6'h0, m_ps};
        return 32'h0;
    endfunction

    task automatic cyc(input logic ev, input logic wr, input logic [5:0] a,
                       input logic [3:0] be, input logic [31:0] wd,
                       input logic prst, input logic aux);
        @(negedge clk);
        pme_event = ev; cfg_wr = wr; cfg_addr = a; cfg_be = be;
        cfg_wdata = wd; pci_rst = prst; aux_por = aux;
        @(posedge clk);
        if (aux) begin
            m_st = 1'b0; m_en = 1'b0; m_ps = 2'b00;
        end else begin
            if (wr && !prst && a == 6'h11) begin
                if (be[1]) begin
                    m_en = wd[8];
                    if (wd[15]) m_st = 1'b0;
                end
                if (be[0] && (wd[1:0] == 2'b00 || wd[1:0] == 2'b11)) m_ps = wd[1:0];
            end
            if (prst) m_ps = 2'b00;
            if (ev) m_st = 1'b1;
        end
        #1;
        if (a == 6'h11) begin
            check("R3 status", {31'h0, cfg_rdata[15]}, {31'h0, m_st});
            check("R9 enable", {31'h0, cfg_rdata[8]}, {31'h0, m_en});
            check("R10 pstate", {30'h0, cfg_rdata[1:0]}, {30'h0, m_ps});
        end
        check("R2 read", cfg_rdata, exp_rd(a));
        check("R6 pme_n", {31'h0, pme_n}, {31'h0, !(m_st && m_en)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R8: power-on reset clears everything
        cyc(1'b1, 1'b1, 6'h11, 4'hF, 32'h0000_8103, 1'b1, 1'b1);
        check("R8 csr after aux", cfg_rdata, 32'h0);
        check("R8 pme_n after aux", {31'h0, pme_n}, 32'h1);
        cyc(1'b0, 1'b0, 6'h10, 4'h0, 32'h0, 1'b0, 1'b0);
        check("R1 header", cfg_rdata, 32'h0022_0001);
        cyc(1'b0, 1'b0, 6'h00, 4'h0, 32'h0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 6'h12, 4'h0, 32'h0, 1'b0, 1'b0);
        // R3: event with enable 0 sets status, pme_n stays high
        cyc(1'b1, 1'b0, 6'h11, 4'h0, 32'h0, 1'b0, 1'b0);
        check("R3 status no enable", {31'h0, cfg_rdata[15]}, 32'h1);
        // R6: enabling drives pme_n low
        cyc(1'b0, 1'b1, 6'h11, 4'h2, 32'h0000_0100, 1'b0, 1'b0);
        check("R6 pme_n low", {31'h0, pme_n}, 32'h0);
        // R9: write without byte 1 does not clear
        cyc(1'b0, 1'b1, 6'h11, 4'h1, 32'h0000_8003, 1'b0, 1'b0);
        check("R9 no be1", cfg_rdata, 32'h0000_8103);
        // R10: unsupported power state ignored
        cyc(1'b0, 1'b1, 6'h11, 4'h1, 32'h0000_0001, 1'b0, 1'b0);
        check("R10 ignore 01", {30'h0, cfg_rdata[1:0]}, 32'h3);
        // R5: event and clear together keep status set
        cyc(1'b1, 1'b1, 6'h11, 4'h2, 32'h0000_8100, 1'b0, 1'b0);
        check("R5 race", {31'h0, cfg_rdata[15]}, 32'h1);
        // R7: PCI reset keeps sticky bits, ignores clear write
        cyc(1'b0, 1'b1, 6'h11, 4'hF, 32'h0000_8000, 1'b1, 1'b0);
        check("R7 sticky", cfg_rdata, 32'h0000_8100);
        cyc(1'b0, 1'b0, 6'h11, 4'h0, 32'h0, 1'b0, 1'b0);
        // R4: write-0 no effect, write-1 clears
        cyc(1'b0, 1'b1, 6'h11, 4'h2, 32'h0000_0100, 1'b0, 1'b0);
        check("R4 write0", {31'h0, cfg_rdata[15]}, 32'h1);
        cyc(1'b0, 1'b1, 6'h11, 4'h2, 32'h0000_8100, 1'b0, 1'b0);
        check("R4 write1", {31'h0, cfg_rdata[15]}, 32'h0);
        // near-exhaustive sweep over event, write, enables, data and reset
        for (int i = 0; i < 2048; i++) begin
            logic [31:0] wd;
            logic [5:0] a;
            wd = {16'hFFFF, i[7], 6'h15, i[8], 6'h2A, i[9], i[5]};
            a = (i % 7 == 3) ? 6'h10 : 6'h11;
            cyc(i[0], i[1] | i[2], a, {i[6], i[10], i[3], i[4]}, wd,
                (i % 11 == 10), (i % 257 == 256));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule